// File: doc/BRIEF.md
# Boot-Time Self-Test and Clear Sequencer

This block runs once after power-up to bring a core into a known state and give it a first health check. It does not rely on a reset net routed to every flop and RAM word. After a start request it walks a clear address across all register and memory words, writing zero to each one. It then drives pseudo-random patterns from a single 32-bit LFSR onto the input buses of several functional units for a programmable number of cycles. At the end it samples the compacted signature returned by the units and compares it with a constant computed offline. It reports done and a pass/fail result.

The expected signature, the LFSR seed, the clear depth, the run length and the number of units are parameters. A build parameter removes all of the sequencing logic. In that variant the outputs are tied to a permanently done and passing, idle state, so a prototype build spends no logic on the test.

Top module: `boot_bist_ctrl`

## Requirements
- R1: While rst_ni is low, and after it is released, the block is idle with done_o=0, pass_o=0, clr_we_o=0, clr_addr_o=0 and stim_o=0. Asserting rst_ni low in the middle of a sequence returns it to this state at once, without waiting for a clock edge.
- R2: start_i is acted on only when the block is idle; it has no effect during the clear, run, check or done phases.
- R3: On the cycle after start_i is accepted, the clear phase begins. It lasts CLR_DEPTH cycles with clr_we_o=1 and clr_addr_o taking the values 0, 1, ..., CLR_DEPTH-1 in order. The write data is implicitly zero. stim_o is 0 during this phase.
- R4: The run phase follows the clear phase and lasts RUN_CYCLES cycles. The LFSR equals SEED in the first run cycle and advances once per cycle by next = {s[30:0], s[31]^s[21]^s[1]^s[0]}, which is the polynomial x^32+x^22+x^2+x+1.
- R5: During the run phase, unit k receives the LFSR state rotated left by (7*k) mod 32 bits, on stim_o[32k+31:32k]. Outside the run phase stim_o is all zero and clr_we_o is 0.
- R6: One check cycle follows the run phase. sig_i is sampled in that cycle, and the result is pass when sig_i equals EXP_SIG in all bits, fail otherwise.
- R7: done_o rises in the cycle after the check cycle and stays high, through the return to idle, until the next accepted start clears it. pass_o is 0 whenever done_o is 0 and does not change while done_o stays high.
- R8: After the check, the block returns to idle only once start_i is low, so a start held high does not launch a second run.
- R9: With BIST_EN=0 the outputs are constant: done_o=1, pass_o=1, clr_we_o=0, clr_addr_o=0 and stim_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, level sampled in idle |
| sig_i | input | SIG_W | Compacted signature from the units under test |
| stim_o | output | N_UNITS*32 | Per-unit pseudo-random stimulus buses |
| clr_addr_o | output | ADDR_W | Word address being cleared |
| clr_we_o | output | 1 | Zero-write enable for the clear sweep |
| done_o | output | 1 | Sequence finished, result valid |
| pass_o | output | 1 | Signature matched (valid with done_o) |

## Verification
The main function is exercised with several signature inputs:
- the exact expected value;
- a value one bit away from it;
- its bitwise complement;
- all zeros.

Together these show whether the compare covers every bit or only part of the word. One run holds start high from the request through the done phase. This separates a design that restarts, or resets its LFSR, on a stray start from one that ignores start outside idle. Every run checks each clear address and each per-unit stimulus word against a model of the polynomial and the rotation. A mid-run reset and the disabled build cover the remaining output states.

// File: rtl/boot_bist_pkg.sv
`timescale 1ns/1ps
package boot_bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_RUN   = 3'd2,
    ST_CHECK = 3'd3,
    ST_DONE  = 3'd4
  } bist_state_e;

  localparam int unsigned LFSR_W = 32;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 32'h8020_0003;  // bits 31,21,1,0
endpackage

// File: rtl/bist_lfsr.sv
`timescale 1ns/1ps
module bist_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] SEED = '1,
  parameter logic [W-1:0] TAPS = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb = ^(q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= SEED;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  assign state_o = q;
endmodule

// File: rtl/bist_stim_fan.sv
`timescale 1ns/1ps
module bist_stim_fan #(
  parameter int unsigned W       = 32,
  parameter int unsigned N_UNITS = 3,
  parameter int unsigned ROT     = 7,
  localparam int unsigned BUS_W  = W * N_UNITS
) (
  input  logic             en_i,
  input  logic [W-1:0]     src_i,
  output logic [BUS_W-1:0] stim_o
);
  for (genvar k = 0; k < N_UNITS; k++) begin : g_unit
    localparam int unsigned R = (k * ROT) % W;
    logic [W-1:0] rot;
    if (R == 0) begin : g_plain
      assign rot = src_i;
    end else begin : g_rot
      assign rot = {src_i[W-1-R:0], src_i[W-1:W-R]};
    end
    assign stim_o[k*W +: W] = en_i ? rot : '0;
  end
endmodule

// File: rtl/bist_clear_walk.sv
`timescale 1ns/1ps
module bist_clear_walk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_q <= '0;
    else if (!en_i) addr_q <= '0;
    else            addr_q <= addr_q + AW'(1);
  end

  assign addr_o = en_i ? addr_q : '0;
  assign last_o = en_i && (addr_q == AW'(DEPTH - 1));
endmodule

// File: rtl/boot_bist_ctrl.sv
`timescale 1ns/1ps
module boot_bist_ctrl #(
  parameter bit          BIST_EN    = 1'b1,
  parameter int unsigned N_UNITS    = 3,
  parameter int unsigned CLR_DEPTH  = 64,
  parameter int unsigned RUN_CYCLES = 100000,
  parameter int unsigned SIG_W      = 32,
  parameter logic [31:0] SEED       = 32'hACE1_2468,
  parameter logic [SIG_W-1:0] EXP_SIG = 32'h5A5A_0F0F,
  localparam int unsigned STIM_W = boot_bist_pkg::LFSR_W,
  localparam int unsigned BUS_W  = STIM_W * N_UNITS,
  localparam int unsigned ADDR_W = (CLR_DEPTH > 1) ? $clog2(CLR_DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(RUN_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SIG_W-1:0]  sig_i,
  output logic [BUS_W-1:0]  stim_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output logic              clr_we_o,
  output logic              done_o,
  output logic              pass_o
);
  import boot_bist_pkg::*;

  if (BIST_EN) begin : g_bist
    bist_state_e      state_q;
    logic [CNT_W-1:0] run_cnt_q;
    logic             done_q, pass_q;
    logic             clr_en, clr_last, run_en;
    logic [STIM_W-1:0] lfsr;

    assign clr_en = (state_q == ST_CLEAR);
    assign run_en = (state_q == ST_RUN);

    bist_clear_walk #(.DEPTH(CLR_DEPTH)) u_clear (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (clr_en),
      .addr_o(clr_addr_o),
      .last_o(clr_last)
    );

    bist_lfsr #(.W(STIM_W), .SEED(SEED), .TAPS(LFSR_TAPS)) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (!run_en),
      .step_i (run_en),
      .state_o(lfsr)
    );

    bist_stim_fan #(.W(STIM_W), .N_UNITS(N_UNITS), .ROT(7)) u_fan (
      .en_i  (run_en),
      .src_i (lfsr),
      .stim_o(stim_o)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q   <= ST_IDLE;
        run_cnt_q <= '0;
        done_q    <= 1'b0;
        pass_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            state_q <= ST_CLEAR;
            done_q  <= 1'b0;
            pass_q  <= 1'b0;
          end
          ST_CLEAR: if (clr_last) begin
            state_q   <= ST_RUN;
            run_cnt_q <= '0;
          end
          ST_RUN: begin
            run_cnt_q <= run_cnt_q + CNT_W'(1);
            if (run_cnt_q == CNT_W'(RUN_CYCLES - 1)) state_q <= ST_CHECK;
          end
          ST_CHECK: begin
            pass_q  <= (sig_i == EXP_SIG);
            done_q  <= 1'b1;
            state_q <= ST_DONE;
          end
          ST_DONE: if (!start_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end

    assign clr_we_o = clr_en;
    assign done_o   = done_q;
    assign pass_o   = pass_q & done_q;
  end else begin : g_off
    logic unused_in;
    assign unused_in  = ^{clk_i, rst_ni, start_i, sig_i};
    assign stim_o     = '0;
    assign clr_addr_o = '0;
    assign clr_we_o   = 1'b0;
    assign done_o     = 1'b1;
    assign pass_o     = 1'b1;
  end
endmodule

// File: rtl/boot_bist_ctrl_chk.sv
`timescale 1ns/1ps
module boot_bist_ctrl_chk #(
  parameter int unsigned BUS_W  = 96,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [BUS_W-1:0]  stim_o,
  input logic [ADDR_W-1:0] clr_addr_o,
  input logic              clr_we_o,
  input logic              done_o,
  input logic              pass_o
);
  AST_CLEAR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_we_o) |-> $past(start_i) && (clr_addr_o == '0)); // R2

  AST_CLEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_o && $past(clr_we_o) |-> clr_addr_o == $past(clr_addr_o) + ADDR_W'(1)); // R3

  AST_NO_STIM_IN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_o |-> stim_o == '0); // R5

  AST_PASS_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> done_o); // R7

  AST_PASS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(done_o) |-> $stable(pass_o)); // R7

  AST_DONE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_we_o) |-> !done_o); // R7
endmodule

bind boot_bist_ctrl boot_bist_ctrl_chk #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .stim_o    (stim_o),
  .clr_addr_o(clr_addr_o),
  .clr_we_o  (clr_we_o),
  .done_o    (done_o),
  .pass_o    (pass_o)
);

// File: tb/boot_bist_ctrl_bench.sv
`timescale 1ns/1ps
module boot_bist_ctrl_bench;
  localparam int unsigned NU    = 3;
  localparam int unsigned DEP   = 5;
  localparam int unsigned RUNS  = 12;
  localparam logic [31:0] SEED  = 32'hACE1_2468;
  localparam logic [31:0] EXP   = 32'h5A5A_0F0F;
  localparam int unsigned BUS_W = 32 * NU;
  localparam int unsigned AW    = $clog2(DEP);

  // {hold_start, exp_pass, sig}
  localparam int NVEC = 5;
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 1'b1, EXP},
    {1'b0, 1'b0, EXP ^ 32'h0001_0000},
    {1'b0, 1'b0, ~EXP},
    {1'b1, 1'b1, EXP},
    {1'b0, 1'b0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [31:0] sig = '0;
  logic [BUS_W-1:0] stim, stim_off;
  logic [AW-1:0] addr, addr_off;
  logic we, done, pass, we_off, done_off, pass_off;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  boot_bist_ctrl #(.N_UNITS(NU), .CLR_DEPTH(DEP), .RUN_CYCLES(RUNS),
                   .SEED(SEED), .EXP_SIG(EXP)) u_boot_bist_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .sig_i(sig),
    .stim_o(stim), .clr_addr_o(addr), .clr_we_o(we), .done_o(done), .pass_o(pass));

  boot_bist_ctrl #(.BIST_EN(1'b0), .N_UNITS(NU), .CLR_DEPTH(DEP), .RUN_CYCLES(RUNS),
                   .SEED(SEED), .EXP_SIG(EXP)) u_boot_bist_ctrl_off (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .sig_i(sig),
    .stim_o(stim_off), .clr_addr_o(addr_off), .clr_we_o(we_off),
    .done_o(done_off), .pass_o(pass_off));

  function automatic logic [31:0] lfsr_next(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [BUS_W-1:0] exp_stim(logic [31:0] s);
    logic [BUS_W-1:0] v;
    for (int k = 0; k < NU; k++) begin
      int r;
      r = (7 * k) % 32;
      v[k*32 +: 32] = (r == 0) ? s : ((s << r) | (s >> (32 - r)));
    end
    return v;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_idle(string req);
    check(req, {we, addr, stim}, '0);
  endtask

  task automatic run_vec(logic [31:0] s_in, logic exp_pass, logic hold);
    logic [31:0] s;
    @(negedge clk);
    start = 1'b1;
    sig = s_in;
    @(negedge clk);
    if (!hold) start = 1'b0;
    check("R7 done cleared on start", done, 1'b0);
    for (int a = 0; a < DEP; a++) begin
      check("R3 clear sweep", {we, addr}, {1'b1, AW'(a)});
      check("R3 no stim in clear", stim, '0);
      @(negedge clk);
    end
    s = SEED;
    for (int r = 0; r < RUNS; r++) begin
      check("R4 R5 stimulus", stim, exp_stim(s));
      check("R2 R5 no clear in run", we, 1'b0);
      s = lfsr_next(s);
      @(negedge clk);
    end
    check("R6 check cycle", {done, we, stim}, '0);
    @(negedge clk);
    check("R6 result", {done, pass}, {1'b1, exp_pass});
    if (hold) begin
      repeat (3) begin
        @(negedge clk);
        check("R8 R2 held start ignored", {done, pass, we}, {1'b1, exp_pass, 1'b0});
      end
      start = 1'b0;
    end
    repeat (2) @(negedge clk);
    check("R7 result held in idle", {done, pass}, {1'b1, exp_pass});
    check_idle("R7 idle outputs");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset outputs", {done, pass}, 2'b00);
    check_idle("R1 reset idle");
    check("R9 disabled build", {done_off, pass_off, we_off, addr_off, stim_off},
          {1'b1, 1'b1, 1'b0, AW'(0), {BUS_W{1'b0}}});
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {done, pass, we, addr, stim}, '0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i][31:0], VEC[i][32], VEC[i][33]);

    // async reset in the middle of a run
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (DEP + 3) @(negedge clk);
    check("R5 mid run active", stim, exp_stim(lfsr_next(lfsr_next(lfsr_next(SEED)))));
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async reset", {done, pass, we, addr, stim}, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", {done, pass, we, addr, stim}, '0);
    run_vec(EXP, 1'b1, 1'b0);
    check("R9 disabled build steady", {done_off, pass_off, we_off, addr_off, stim_off},
          {1'b1, 1'b1, 1'b0, AW'(0), {BUS_W{1'b0}}});

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule